// File: doc/BRIEF.md
# Receive Tag Strip and Buffer Scatter

This block sits on the receive path of an Ethernet controller. Its input is a frame that arrives one byte per cycle, with markers for the first and last byte. A frame shorter than the minimum is extended with zero bytes. A frame longer than the active size limit is discarded. When tag removal is enabled and the frame's type field equals the programmed tag type, the four tag bytes are taken out of the stream and the 16-bit tag control value is kept aside.

The remaining bytes are spread across a run of equal receive buffers, one buffer for each descriptor. The buffer size is an input. Each byte leaves as a write strobe that carries the descriptor index within the frame, the byte offset inside that buffer, and the data. After the last byte of a frame, the block issues one completion record for each descriptor it used, on consecutive cycles. A record holds the length written to that buffer, a status field and the tag.

Top module: `rx_vlan_scatter`

## Requirements
- R1: After reset, and until a byte marked as frame start arrives, neither `wr_en` nor `cmp_valid` is asserted.
- R2: A frame of fewer than 60 bytes is extended with zero bytes to exactly 60. The extension happens before tag detection, so padded positions take part in the type comparison.
- R3: With `large_en` low, a frame longer than 1522 bytes is discarded. With `large_en` high, the limit is 16384 bytes. A discarded frame produces no completion record, and no write strobe once its length passes the limit. A frame exactly at the limit is kept.
- R4: Tag removal happens when `vlan_en` is high and padded bytes 12 (high) and 13 (low) equal `vlan_type`. The tag control value is then byte 14 (high) and byte 15 (low).
- R5: In a frame with the tag removed, padded bytes 12 to 15 are absent from the output. All other bytes keep their order, and the output length is the padded length minus 4.
- R6: When `vlan_en` is low or the type does not match, every padded byte is written unchanged. Status bit 2 is 0 and `cmp_tag` is 0.
- R7: Output byte k (counted from 0) is written to descriptor k / `buf_size` at offset k mod `buf_size`. Exactly one strobe is issued per output byte.
- R8: For a kept frame of output length L, the block issues n = ceil(L / `buf_size`) records with indices 0 to n-1 on consecutive cycles. Every record's length is `buf_size`, except the last, which carries L - (n-1)*`buf_size`. In `cmp_stat`, bit 0 (done) is 1 in every record and bit 1 (end of packet) is 1 only in the last. Bit 2 (tag removed) and `cmp_tag` are the same in all records of a frame.
- R9: Bytes offered while idle without the start marker are ignored. Cycles with `in_valid` low inside a frame pause the frame without changing its content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| vlan_en | input | 1 | Enables tag detection and removal |
| vlan_type | input | 16 | Type value that identifies a tagged frame |
| large_en | input | 1 | Selects the large frame size limit |
| buf_size | input | BUF_W | Receive buffer size in bytes |
| wr_en | output | 1 | Buffer write strobe |
| wr_desc | output | DESC_W | Descriptor index within the frame |
| wr_off | output | BUF_W | Byte offset within the buffer |
| wr_data | output | 8 | Byte to write |
| cmp_valid | output | 1 | Completion record present |
| cmp_idx | output | DESC_W | Descriptor index of the record |
| cmp_len | output | BUF_W | Bytes written to that buffer |
| cmp_stat | output | 3 | {tag removed, end of packet, done} |
| cmp_tag | output | 16 | Tag control value, 0 when no tag was removed |

## Verification
The assertions assume three things about the inputs. `buf_size` is nonzero and holds still through a frame and its completion burst. The tag controls do not change during a frame. A new start marker never arrives before the previous frame's completion records are finished. The stimulus changes configuration only between frames, always while the block is idle. It also waits for the end-of-packet record, or a fixed quiet period after a discarded frame, before starting the next frame. Buffer sizes in the sweep stay between 16 and 256, so every offset and length fits the chosen widths.

// File: rtl/rx_vlan_scatter.sv
`timescale 1ns/1ps
module rx_vlan_scatter #(
  parameter int BUF_W     = 15,
  parameter int DESC_W    = 11,
  parameter int CNT_W     = 15,
  parameter int MIN_LEN   = 60,
  parameter int MAX_STD   = 1522,
  parameter int MAX_LARGE = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic              vlan_en,
  input  logic [15:0]       vlan_type,
  input  logic              large_en,
  input  logic [BUF_W-1:0]  buf_size,
  output logic              wr_en,
  output logic [DESC_W-1:0] wr_desc,
  output logic [BUF_W-1:0]  wr_off,
  output logic [7:0]        wr_data,
  output logic              cmp_valid,
  output logic [DESC_W-1:0] cmp_idx,
  output logic [BUF_W-1:0]  cmp_len,
  output logic [2:0]        cmp_stat,
  output logic [15:0]       cmp_tag
);
  // two-byte hold: the type decision is made before byte 12 leaves
  localparam int DLY  = 2;
  localparam int TPOS = 12;
  localparam logic [CNT_W-1:0] P_DLY  = CNT_W'(DLY);
  localparam logic [CNT_W-1:0] P_T0   = CNT_W'(TPOS);
  localparam logic [CNT_W-1:0] P_T1   = CNT_W'(TPOS + 1);
  localparam logic [CNT_W-1:0] P_T2   = CNT_W'(TPOS + 2);
  localparam logic [CNT_W-1:0] P_T3   = CNT_W'(TPOS + 3);
  localparam logic [CNT_W-1:0] P_GLO  = CNT_W'(TPOS + DLY);
  localparam logic [CNT_W-1:0] P_GHI  = CNT_W'(TPOS + DLY + 4);
  localparam logic [CNT_W:0]   L_MIN  = (CNT_W+1)'(MIN_LEN);
  localparam logic [CNT_W:0]   L_STD  = (CNT_W+1)'(MAX_STD);
  localparam logic [CNT_W:0]   L_BIG  = (CNT_W+1)'(MAX_LARGE);

  typedef enum logic [2:0] {S_IDLE, S_IN, S_PAD, S_FLUSH, S_CMP} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sh0, sh1, thi;
  logic             drop, strip, fcnt;
  logic [15:0]      tag;
  logic [DESC_W-1:0] wdesc, cidx;
  logic [BUF_W-1:0] woff;

  wire start   = (st == S_IDLE) && in_valid && in_sof;
  wire tick    = start || (st == S_IN && in_valid) || st == S_PAD || st == S_FLUSH;
  wire [CNT_W-1:0] pos = start ? '0 : cnt;
  wire [7:0]   nb      = (st == S_PAD || st == S_FLUSH) ? 8'h00 : in_data;
  wire         live    = tick && st != S_FLUSH;
  wire         drop_c  = start ? 1'b0 : drop;
  wire         strip_c = start ? 1'b0 : strip;
  wire [CNT_W:0] nxt   = {1'b0, pos} + 1'b1;
  wire [CNT_W:0] lim   = large_en ? L_BIG : L_STD;
  wire         over    = (st == S_IN) && (nxt > lim);
  wire         gap     = strip_c && pos >= P_GLO && pos < P_GHI;
  wire         emit    = tick && pos >= P_DLY && !drop_c && !gap;
  wire         buf_end = woff == buf_size - 1'b1;
  wire [DESC_W-1:0] ndesc = wdesc + DESC_W'(woff != '0);
  wire         clast   = cidx == ndesc - 1'b1;

  assign cmp_valid = st == S_CMP;
  assign cmp_idx   = cidx;
  assign cmp_len   = (clast && woff != '0) ? woff : buf_size;
  assign cmp_stat  = {strip, clast, 1'b1};
  assign cmp_tag   = strip ? tag : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;   sh0 <= '0;   sh1 <= '0;   thi <= '0;
      drop <= 1'b0;  strip <= 1'b0; fcnt <= 1'b0; tag <= '0;
      wdesc <= '0;   woff <= '0;  cidx <= '0;
      wr_en <= 1'b0; wr_desc <= '0; wr_off <= '0; wr_data <= '0;
    end else begin
      wr_en <= emit;
      if (emit) begin
        wr_data <= sh1;
        wr_desc <= wdesc;
        wr_off  <= woff;
        if (buf_end) begin
          woff  <= '0;
          wdesc <= wdesc + 1'b1;
        end else begin
          woff <= woff + 1'b1;
        end
      end
      if (tick) begin
        sh1 <= sh0;
        sh0 <= nb;
      end
      case (st)
        S_IDLE: if (start) begin
          cnt <= 1;      drop <= 1'b0; strip <= 1'b0; tag <= '0;
          wdesc <= '0;   woff <= '0;   cidx <= '0;
          st <= in_eof ? S_PAD : S_IN;
        end
        S_IN: if (in_valid) begin
          if (!(drop || over)) cnt <= nxt[CNT_W-1:0];
          drop <= drop | over;
          if (in_eof)
            st <= (drop || over) ? S_IDLE : (nxt < L_MIN ? S_PAD : S_FLUSH);
        end
        S_PAD: begin
          cnt <= nxt[CNT_W-1:0];
          if (nxt == L_MIN) st <= S_FLUSH;
        end
        S_FLUSH: begin
          cnt  <= nxt[CNT_W-1:0];
          fcnt <= ~fcnt;
          if (fcnt) begin
            st   <= S_CMP;
            cidx <= '0;
          end
        end
        S_CMP: begin
          cidx <= cidx + 1'b1;
          if (clast) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (live && pos == P_T0) thi <= nb;
      if (live && pos == P_T1) strip <= vlan_en && ({thi, nb} == vlan_type);
      if (live && pos == P_T2) tag[15:8] <= nb;
      if (live && pos == P_T3) tag[7:0] <= nb;
    end
  end

  p_wr_in_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_off < buf_size);
  p_len_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> (cmp_len != '0 && cmp_len <= buf_size));
  p_first_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_valid) |-> cmp_idx == '0);
  p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_stat[1]) |=> (cmp_valid && cmp_idx == $past(cmp_idx) + 1'b1));
  p_eop_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_stat[1]) |=> !cmp_valid);
  p_tag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_stat[2]) |-> cmp_tag == 16'h0000);
  p_drop_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (!wr_en && !cmp_valid));
  p_strip_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && $past(cmp_valid)) |-> ($stable(cmp_tag) && $stable(cmp_stat[2])));
endmodule

// File: tb/rx_vlan_scatter_tb.sv
`timescale 1ns/1ps
module rx_vlan_scatter_tb_top;
  localparam int BW = 15, DW = 11, MEM = 16512, RMAX = 1100;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic in_valid = 0, in_sof = 0, in_eof = 0, vlan_en = 0, large_en = 0;
  logic [7:0] in_data = 0;
  logic [15:0] vlan_type = 16'h8100;
  logic [BW-1:0] buf_size = 16;
  logic wr_en, cmp_valid;
  logic [DW-1:0] wr_desc, cmp_idx;
  logic [BW-1:0] wr_off, cmp_len;
  logic [7:0] wr_data;
  logic [2:0] cmp_stat;
  logic [15:0] cmp_tag;

  rx_vlan_scatter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .vlan_en(vlan_en), .vlan_type(vlan_type), .large_en(large_en),
    .buf_size(buf_size), .wr_en(wr_en), .wr_desc(wr_desc), .wr_off(wr_off),
    .wr_data(wr_data), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_len(cmp_len),
    .cmp_stat(cmp_stat), .cmp_tag(cmp_tag));

  int nchk = 0, nerr = 0, cyc = 0, nfr = 0;
  logic [7:0] got [0:MEM-1];
  logic [7:0] pd  [0:MEM-1];
  logic [7:0] ex  [0:MEM-1];
  int r_idx [0:RMAX-1];
  int r_len [0:RMAX-1];
  int r_stat[0:RMAX-1];
  int r_tag [0:RMAX-1];
  int nrec = 0, nwr = 0, cur_bsz = 16;
  bit done_f = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    int a;
    if (rst_n) begin
      if (wr_en) begin
        a = int'(wr_desc) * cur_bsz + int'(wr_off);
        if (a < MEM) got[a] = wr_data;
        nwr++;
      end
      if (cmp_valid) begin
        if (nrec < RMAX) begin
          r_idx[nrec] = int'(cmp_idx); r_len[nrec] = int'(cmp_len);
          r_stat[nrec] = int'(cmp_stat); r_tag[nrec] = int'(cmp_tag);
        end
        nrec++;
        if (cmp_stat[1]) done_f = 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic run_frame(input int n, input int mode, input int bsz, input bit lpe,
                           input bit gaps, input bit stray);
    logic [15:0] vt, tg, etag;
    int np, L, nd, bad, bi, ba, be;
    bit strip, dropped;
    string rq;
    vt = 16'h8100;
    tg = 16'(16'h5a00 + nfr * 37);
    nfr++;
    np = (n < 60) ? 60 : n;
    for (int i = 0; i < np; i++) pd[i] = (i < n) ? 8'(i * 13 + nfr * 5 + 1) : 8'h00;
    if (mode != 0) begin
      if (n > 12) pd[12] = vt[15:8];
      if (n > 13) pd[13] = (mode == 1) ? vt[7:0] : 8'h01;
      if (n > 14) pd[14] = tg[15:8];
      if (n > 15) pd[15] = tg[7:0];
    end
    strip = (mode != 0) && ({pd[12], pd[13]} == vt);
    etag = strip ? {pd[14], pd[15]} : 16'h0000;
    L = strip ? np - 4 : np;
    for (int k = 0; k < L; k++) ex[k] = (strip && k >= 12) ? pd[k + 4] : pd[k];
    nd = (L + bsz - 1) / bsz;
    dropped = n > (lpe ? 16384 : 1522);

    @(negedge clk);
    vlan_en = (mode != 0); vlan_type = vt; large_en = lpe; buf_size = BW'(bsz);
    cur_bsz = bsz; nrec = 0; nwr = 0; done_f = 0;
    for (int i = 0; i < MEM; i++) got[i] = 8'hxx;
    if (stray) begin
      for (int i = 0; i < 3; i++) begin
        in_valid = 1; in_sof = 0; in_eof = 1; in_data = 8'(8'hc0 + i);
        @(negedge clk);
      end
    end
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = pd[i];
      @(negedge clk);
      if (gaps && (i % 7) == 3) begin
        in_valid = 0; in_sof = 0; in_eof = 0;
        repeat (2) @(negedge clk);
      end
    end
    in_valid = 0; in_sof = 0; in_eof = 0;

    if (dropped) begin
      repeat (30) @(negedge clk);
      chk(nrec == 0, "R3", "records of dropped frame", nrec, 0);
      chk(nwr <= (lpe ? 16384 : 1522), "R3", "writes of dropped frame", nwr, lpe ? 16384 : 1522);
      return;
    end
    for (int w = 0; w < n * 3 + 400 && !done_f; w++) @(negedge clk);
    repeat (3) @(negedge clk);

    chk(nrec == nd, "R8", "record count", nrec, nd);
    chk(nwr == L, "R7", "write count", nwr, L);
    if (gaps || stray) chk(nwr == L, "R9", "writes with gaps or stray bytes", nwr, L);
    bad = -1;
    for (int k = 0; k < L; k++) if (bad < 0 && got[k] !== ex[k]) bad = k;
    rq = (n < 60) ? "R2" : strip ? "R5" : (mode != 0) ? "R6" : "R7";
    if (bad < 0) chk(1'b1, rq, "data", 0, 0);
    else chk(1'b0, rq, $sformatf("data byte %0d", bad), int'(got[bad]), int'(ex[bad]));
    bi = -1; ba = 0; be = 0;
    for (int k = 0; k < nrec && k < nd && k < RMAX; k++) begin
      int el, es;
      el = (k < nd - 1) ? bsz : L - (nd - 1) * bsz;
      es = (k == nd - 1) ? 3 : 1;
      if (bi < 0 && r_idx[k] != k) begin bi = k; ba = r_idx[k]; be = k; end
      if (bi < 0 && r_len[k] != el) begin bi = k; ba = r_len[k]; be = el; end
      if (bi < 0 && (r_stat[k] & 3) != es) begin bi = k; ba = r_stat[k] & 3; be = es; end
    end
    chk(bi < 0, "R8", $sformatf("record %0d fields", bi), ba, be);
    bi = -1;
    for (int k = 0; k < nrec && k < RMAX; k++)
      if (bi < 0 && (((r_stat[k] >> 2) & 1) != int'(strip) || r_tag[k] != int'(etag))) bi = k;
    if (bi < 0) chk(1'b1, strip ? "R4" : "R6", "tag status", 0, 0);
    else chk(1'b0, strip ? "R4" : "R6", $sformatf("tag of record %0d", bi), r_tag[bi], int'(etag));
  endtask

  initial begin
    int sizes[4];
    int lens[10];
    sizes = '{16, 24, 60, 64};
    lens  = '{1, 13, 40, 59, 60, 61, 64, 65, 100, 129};
    repeat (4) @(negedge clk);
    rst_n = 1;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 8; i++) begin
        in_valid = (i > 3); in_sof = 0; in_data = 8'(i);
        @(negedge clk);
        if (wr_en || cmp_valid) seen++;
      end
      in_valid = 0;
      chk(seen == 0, "R1", "activity after reset", seen, 0);
      repeat (4) @(negedge clk);
      chk(nwr == 0 && nrec == 0, "R9", "stray idle bytes", nwr + nrec, 0);
    end
    foreach (sizes[s]) foreach (lens[l]) for (int m = 0; m < 3; m++)
      run_frame(lens[l], m, sizes[s], 1'b0, lens[l] % 2 == 1, m == 2);
    run_frame(1522, 1, 64, 1'b0, 1'b0, 1'b0);
    run_frame(1523, 0, 64, 1'b0, 1'b0, 1'b0);
    run_frame(70, 1, 16, 1'b0, 1'b0, 1'b0);
    run_frame(1523, 2, 100, 1'b1, 1'b1, 1'b0);
    run_frame(16384, 1, 256, 1'b1, 1'b0, 1'b0);
    run_frame(16385, 0, 256, 1'b1, 1'b0, 1'b0);
    run_frame(61, 1, 24, 1'b0, 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule